// File: doc/BRIEF.md
# Reset Release Time-out Sequencer

This block keeps the processor core in reset after a supply-level event and lets it run only after a chain of waits has finished. A supply event is a power-on or brown-out level coming from the analog detectors. After the event input falls, up to three stages run in a fixed order: a power-up delay counted in slow timebase ticks, an oscillator start-up count of core clock periods, and a PLL lock wait, also counted in ticks. The oscillator mode code and the power-up delay enable select which stages run.

A wake-up from sleep, or an oscillator switch, leaves the core running in DONE and reruns only the oscillator-related stages. The external reset pin only gates the output. It never restarts the timers. If the pin is still low when the chain has finished, the core starts on the first clock edge after the pin goes high. The output is a registered run enable in the core clock domain.

Top module: `rst_seq_top`

## Requirements
- R1: While `rst_ni` is low, `run_o` is 0 and the sequencer is held at the start of the chain.
- R2: While `por_i` or `bor_i` is high, `run_o` is 0 from the next rising edge on. The chain begins on the first rising edge after both are low.
- R3: The power-up delay stage runs only after a supply event, only with `pwrt_en_i`=1, and only when `osc_mode_i` is not 2'b00. It lasts until PWRT_TICKS clock edges have seen `tick_i`=1 and does not advance without ticks.
- R4: In crystal modes (`osc_mode_i` 2'b10 and 2'b11), an oscillator start-up stage of exactly OST_CYCLES clock cycles follows the power-up delay stage, or the start of the chain when that stage is skipped.
- R5: In mode 2'b11 (crystal with PLL), a PLL lock stage of PLL_TICKS ticks follows the oscillator start-up stage.
- R6: Mode 2'b00 (external clock) never adds delay. Mode 2'b01 (RC) adds only the power-up delay stage. With S being the summed stage lengths in edges, `run_o` rises on rising edge 1+S after the supply event ends.
- R7: A one-cycle `wake_i` while running skips the power-up delay stage and runs only the start-up and PLL stages. `run_o` rises on edge 1+S after the pulse and never drops in modes 2'b00 and 2'b01. `wake_i` has no effect while the chain is still running.
- R8: `ext_rst_ni`=0 forces `run_o` to 0 on the next edge and does not stop the timers. Once the chain has finished, raising the pin sets `run_o` on the next rising edge.
- R9: A supply event during any stage restarts the chain from the first stage.
- R10: A brown-out event runs the same chain as a power-on event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core/oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | Power-on detect level, high while active |
| bor_i | input | 1 | Brown-out detect level, high while active |
| ext_rst_ni | input | 1 | External reset pin level, active low |
| tick_i | input | 1 | Slow timebase tick, one clock wide |
| osc_mode_i | input | 2 | 00 external clock, 01 RC, 10 crystal, 11 crystal with PLL |
| pwrt_en_i | input | 1 | Power-up delay stage enable |
| wake_i | input | 1 | Wake-from-sleep or oscillator-switch request |
| run_o | output | 1 | Core run enable (1 = out of reset) |

## Verification
A wrong stage decode or a bad counter compare shows up as a release edge that is off by whole stage lengths, or by one edge. The bench counts edges exactly from the event release, so it catches both within the very run that exposes them. A chain that fails to restart or to skip a stage shows up within one chain length as an edge count that is too short or too long. Errors in the pin gating or the event hold show up on the `run_o` value one edge after the input changes.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [2:0] {
    ST_HOLD = 3'd0,
    ST_PWRT = 3'd1,
    ST_OST  = 3'd2,
    ST_PLL  = 3'd3,
    ST_DONE = 3'd4
  } seq_st_e;

  typedef enum logic [1:0] {
    OSC_EXT      = 2'b00,
    OSC_RC       = 2'b01,
    OSC_XTAL     = 2'b10,
    OSC_XTAL_PLL = 2'b11
  } osc_mode_e;

  localparam int unsigned N_STAGE = 3; // pwrt, ost, pll
endpackage

// File: rtl/seq_cnt.sv
module seq_cnt #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = inc_i && (cnt_q == LAST);
endmodule

// File: rtl/seq_plan.sv
module seq_plan
  import rst_seq_pkg::*;
(
  input  logic [1:0] osc_mode_i,
  input  logic       pwrt_en_i,
  output seq_st_e    first_pwr_o,
  output seq_st_e    first_wake_o,
  output seq_st_e    after_pwrt_o,
  output seq_st_e    after_ost_o
);
  logic need_pwrt, need_ost, need_pll;

  always_comb begin
    need_pwrt = pwrt_en_i && (osc_mode_i != OSC_EXT);
    need_ost  = osc_mode_i[1];
    need_pll  = (osc_mode_i == OSC_XTAL_PLL);
  end

  always_comb begin
    after_ost_o  = need_pll ? ST_PLL : ST_DONE;
    after_pwrt_o = need_ost ? ST_OST : after_ost_o;
    first_wake_o = after_pwrt_o;
    first_pwr_o  = need_pwrt ? ST_PWRT : after_pwrt_o;
  end
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int unsigned PWRT_TICKS = 72,
  parameter int unsigned OST_CYCLES = 1024,
  parameter int unsigned PLL_TICKS  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_i,
  input  logic       bor_i,
  input  logic       ext_rst_ni,
  input  logic       tick_i,
  input  logic [1:0] osc_mode_i,
  input  logic       pwrt_en_i,
  input  logic       wake_i,
  output logic       run_o
);
  seq_st_e st_q, st_d;
  seq_st_e first_pwr, first_wake, after_pwrt, after_ost;
  logic    pwr_evt;
  logic    run_q;
  logic [N_STAGE-1:0] stg_last;

  function automatic int unsigned stage_limit(int unsigned idx);
    case (idx)
      0:       return PWRT_TICKS;
      1:       return OST_CYCLES;
      default: return PLL_TICKS;
    endcase
  endfunction

  function automatic seq_st_e stage_id(int unsigned idx);
    case (idx)
      0:       return ST_PWRT;
      1:       return ST_OST;
      default: return ST_PLL;
    endcase
  endfunction

  assign pwr_evt = por_i | bor_i;

  seq_plan u_plan (
    .osc_mode_i   (osc_mode_i),
    .pwrt_en_i    (pwrt_en_i),
    .first_pwr_o  (first_pwr),
    .first_wake_o (first_wake),
    .after_pwrt_o (after_pwrt),
    .after_ost_o  (after_ost)
  );

  // OST counts core clocks; timer stages count timebase ticks
  for (genvar g = 0; g < N_STAGE; g++) begin : g_stage
    logic inc;
    assign inc = (g == 1) ? 1'b1 : tick_i;
    seq_cnt #(.LIMIT(stage_limit(g))) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (st_q != stage_id(g)),
      .inc_i  (inc),
      .last_o (stg_last[g])
    );
  end

  always_comb begin
    st_d = st_q;
    if (pwr_evt) begin
      st_d = ST_HOLD;
    end else begin
      unique case (st_q)
        ST_HOLD: st_d = first_pwr;
        ST_PWRT: if (stg_last[0]) st_d = after_pwrt;
        ST_OST:  if (stg_last[1]) st_d = after_ost;
        ST_PLL:  if (stg_last[2]) st_d = ST_DONE;
        ST_DONE: if (wake_i)      st_d = first_wake;
        default: st_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_HOLD;
      run_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      run_q <= (st_d == ST_DONE) && ext_rst_ni;
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       por_i,
  input logic       bor_i,
  input logic       ext_rst_ni,
  input logic       tick_i,
  input logic [1:0] osc_mode_i,
  input logic       pwrt_en_i,
  input logic       wake_i,
  input logic       run_o
);
  p_evt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_i || bor_i) |=> !run_o);

  p_pin_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_rst_ni |=> !run_o);

  p_rise_clean_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> ($past(ext_rst_ni) && !$past(por_i) && !$past(bor_i)));

  p_ext_clk_fast_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_mode_i == 2'b00 && !por_i && !bor_i && ext_rst_ni) |=> run_o);

  p_pwrt_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(run_o) && osc_mode_i == 2'b01 && pwrt_en_i && $past(ext_rst_ni, 2))
      |-> $past(tick_i));

  p_wake_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && wake_i && !osc_mode_i[1] && !por_i && !bor_i && ext_rst_ni) |=> run_o);
endmodule

bind rst_seq_top rst_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .por_i      (por_i),
  .bor_i      (bor_i),
  .ext_rst_ni (ext_rst_ni),
  .tick_i     (tick_i),
  .osc_mode_i (osc_mode_i),
  .pwrt_en_i  (pwrt_en_i),
  .wake_i     (wake_i),
  .run_o      (run_o)
);

// File: tb/rst_seq_top_bench.sv
module rst_seq_top_bench;
  localparam int P = 5;
  localparam int O = 16;
  localparam int L = 3;

  typedef struct packed {
    logic [1:0]  kind;  // 0 por, 1 bor, 2 wake
    logic [1:0]  mode;
    logic        pwrt;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{2'd0, 2'b00, 1'b1, 16'(1)},
    '{2'd0, 2'b01, 1'b1, 16'(1 + P)},
    '{2'd0, 2'b01, 1'b0, 16'(1)},
    '{2'd0, 2'b10, 1'b1, 16'(1 + P + O)},
    '{2'd1, 2'b10, 1'b0, 16'(1 + O)},
    '{2'd0, 2'b11, 1'b1, 16'(1 + P + O + L)},
    '{2'd1, 2'b11, 1'b0, 16'(1 + O + L)},
    '{2'd1, 2'b00, 1'b0, 16'(1)},
    '{2'd2, 2'b11, 1'b1, 16'(1 + O + L)},
    '{2'd2, 2'b10, 1'b1, 16'(1 + O)},
    '{2'd2, 2'b01, 1'b1, 16'(1)},
    '{2'd2, 2'b00, 1'b1, 16'(1)}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       por_i = 1'b1;
  logic       bor_i = 1'b0;
  logic       ext_rst_ni = 1'b1;
  logic       tick_i = 1'b1;
  logic [1:0] osc_mode_i = 2'b00;
  logic       pwrt_en_i = 1'b1;
  logic       wake_i = 1'b0;
  logic       run_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rst_seq_top #(.PWRT_TICKS(P), .OST_CYCLES(O), .PLL_TICKS(L)) u_rst_seq_top (
    .clk_i(clk), .rst_ni(rst_ni), .por_i(por_i), .bor_i(bor_i),
    .ext_rst_ni(ext_rst_ni), .tick_i(tick_i), .osc_mode_i(osc_mode_i),
    .pwrt_en_i(pwrt_en_i), .wake_i(wake_i), .run_o(run_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts rising edges until run_o is seen high; optional wake/bor pulses at edge counts
  task automatic measure(input int wake_at, input int bor_at, output int n);
    n = 0;
    wake_i = (wake_at == 0);
    do begin
      @(posedge clk);
      @(negedge clk);
      n++;
      wake_i = (n == wake_at);
      bor_i  = (n == bor_at);
    end while (!run_o && n < 400);
    wake_i = 1'b0;
    bor_i  = 1'b0;
  endtask

  task automatic power_event(input logic [1:0] mode, input logic pwrt, input bit use_bor);
    @(negedge clk);
    osc_mode_i = mode;
    pwrt_en_i  = pwrt;
    por_i      = !use_bor;
    bor_i      = use_bor;
    repeat (3) @(negedge clk);
  endtask

  task automatic release_events();
    por_i = 1'b0;
    bor_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(run_o == 1'b0, "R1 reset state", int'(run_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(run_o == 1'b0, "R2 held by power-on level", int'(run_o), 0);

    // table walk: R3 R4 R5 R6 R7 R10
    for (int i = 0; i < 12; i++) begin
      power_event(VECS[i].mode, VECS[i].pwrt, VECS[i].kind == 2'd1);
      if (VECS[i].kind != 2'd2)
        check(run_o == 1'b0, $sformatf("R2 vec %0d held", i), int'(run_o), 0);
      release_events();
      measure(-1, -1, n);
      if (VECS[i].kind == 2'd2) measure(0, -1, n);
      check(n == int'(VECS[i].exp),
            $sformatf("R6/R7/R10 vec %0d release edge", i), n, int'(VECS[i].exp));
    end

    // R3: power-up delay stalls without ticks
    tick_i = 1'b0;
    power_event(2'b01, 1'b1, 1'b0);
    release_events();
    repeat (50) @(negedge clk);
    check(run_o == 1'b0, "R3 no ticks no release", int'(run_o), 0);
    tick_i = 1'b1;
    measure(-1, -1, n);
    check(n == P, "R3 ticks resume", n, P);

    // R9: brown-out in start-up stage restarts chain
    power_event(2'b10, 1'b1, 1'b0);
    release_events();
    measure(-1, P + 3, n);
    check(n == (P + 3) + 2 + P + O, "R9 restart", n, (P + 3) + 2 + P + O);

    // R7: wake during chain ignored
    power_event(2'b10, 1'b0, 1'b0);
    release_events();
    measure(5, -1, n);
    check(n == 1 + O, "R7 wake ignored mid-chain", n, 1 + O);

    // R8: pin held low past time-outs
    power_event(2'b11, 1'b1, 1'b0);
    ext_rst_ni = 1'b0;
    release_events();
    repeat (1 + P + O + L + 10) @(negedge clk);
    check(run_o == 1'b0, "R8 pin low holds", int'(run_o), 0);
    ext_rst_ni = 1'b1;
    measure(-1, -1, n);
    check(n == 1, "R8 immediate release", n, 1);
    ext_rst_ni = 1'b0;
    @(negedge clk);
    check(run_o == 1'b0, "R8 pin low while running", int'(run_o), 0);
    ext_rst_ni = 1'b1;
    @(negedge clk);
    check(run_o == 1'b1, "R8 pin high again", int'(run_o), 1);

    // R1: asynchronous reset while running
    rst_ni = 1'b0;
    #1;
    check(run_o == 1'b0, "R1 async reset", int'(run_o), 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule